// File: doc/BRIEF.md
# Sector Protection Register Responder

This block is the device side of a serial flash's sector protection register. A host selects it by pulling the active-low select low and then clocks command bytes in on the data input. A read command returns the 32 protection bytes, one per sector and lowest sector first. A program command replaces all 32 bytes. The register storage, the data buffer used by programming, and the output enable that stands in for a tri-state pin are all inside the block.

The parameter `BUS_W` picks the transfer width. With `BUS_W = 1` each byte arrives as eight bits, most significant bit first. With `BUS_W = 8` a whole byte moves on each serial clock. Input is sampled on the rising edge of the serial clock and output changes on its falling edge. The serial clock and the select are sampled in the system clock domain, so each high and low phase of the serial clock must last at least one system clock.

Top module: `prot_flash_responder`

## Requirements
- R1: After reset all 32 protection bytes are 0x00 and `dataOutEn` is low. A read with no program before it returns 0x00 for every sector.
- R2: The read command is the first byte 0x32. It is followed by dummy bytes: 3 when `BUS_W = 1` and 7 when `BUS_W = 8`. `dataOutEn` stays low while the opcode and the dummy bytes are transferred.
- R3: On the falling serial clock edge after the last dummy byte, the block starts driving with `dataOutEn` high. It streams sector 0's byte first, then sector 1 and so on up to sector 31. When serial, each byte goes out MSB first, one bit per falling edge.
- R4: Once the 32nd byte has been sent, further clocks return the filler byte 0xFF with `dataOutEn` still high.
- R5: When the select goes high, `dataOutEn` goes low within one system clock. The next read starts again at sector 0.
- R6: Programming needs the exact first four bytes 0x3D, 0x2A, 0x7F, 0xFC. If any of them differs, the register is left unchanged.
- R7: If the first byte is neither 0x32 nor 0x3D, the block ignores all traffic until the select goes high. It drives nothing, and a read or program sequence sent later in the same selection has no effect.
- R8: Program data bytes are written in order into buffer positions 0 upwards. On the select rising edge the whole 32-byte buffer is copied into the register. Positions that this command did not write keep the buffer's earlier contents, which are the data of the previous program commands.
- R9: If the select rises partway through a serial data byte, the register is left unchanged. The complete bytes before it still reach the buffer.
- R10: Program data bytes after the 32nd are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock; rising edge samples, falling edge drives |
| dataIn | input | BUS_W | Serial or byte-wide data from the host |
| dataOut | output | BUS_W | Data to the host, zero when not driven |
| dataOutEn | output | 1 | Output enable; low means the pin is high impedance |

## Verification
The hardest case to reach is the interaction between the shared buffer and the commit rule. A discarded program with a partial last byte still leaves its whole bytes in the buffer, and the only way to see them is through a later program. The stimulus therefore sends a program that is cut three bits into a byte and checks that the register did not change. It then sends a valid program header with no data bytes, which commits the buffer as it stands, and reads back the bytes that the discarded command left behind. A second ordering sends a short program after a full one, so that the read shows new bytes in the low sectors and older buffer contents in the rest.

// File: rtl/prot_flash_pkg.sv
package prot_flash_pkg;

  localparam int NUM_SECTORS = 32;
  localparam int SECT_IDX_W  = $clog2(NUM_SECTORS);
  localparam logic [7:0] OP_READ   = 8'h32;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_PGMHDR,
    ST_PGMDATA,
    ST_RDDUMMY,
    ST_RDDATA,
    ST_IGNORE
  } ctrlState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic                  bufWe;
    logic [SECT_IDX_W-1:0] bufIdx;
    logic                  commit;
    logic                  outLoad;
    logic                  outStep;
    logic                  outEn;
  } dpStrobe_t;

  // program header, checked byte by byte in this order
  function automatic logic [7:0] progByte(input logic [1:0] idx);
    case (idx)
      2'd0:    progByte = 8'h3D;
      2'd1:    progByte = 8'h2A;
      2'd2:    progByte = 8'h7F;
      default: progByte = 8'hFC;
    endcase
  endfunction

endpackage

// File: rtl/prot_flash_dp.sv
module prot_flash_dp
  import prot_flash_pkg::*;
#(
  parameter int BUS_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sck,
  input  logic [BUS_W-1:0] dataIn,
  input  dpStrobe_t        strobe,
  output logic             sckFall,
  output logic             csRise,
  output logic             byteValid,
  output logic [7:0]       byteVal,
  output logic             partial,
  output logic [BUS_W-1:0] dataOut
);

  localparam int XFERS    = 8 / BUS_W;
  localparam int SUB_W    = $clog2(XFERS);
  localparam int POS_SAT  = NUM_SECTORS * XFERS;
  localparam int POS_W    = $clog2(POS_SAT + 1);

  logic sckQ;
  logic csQ;
  logic sckRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ <= 1'b0;
      csQ  <= 1'b1;
    end else begin
      sckQ <= sck;
      csQ  <= csN;
    end
  end

  assign sckRise = sck & ~sckQ;
  assign sckFall = ~sck & sckQ;
  assign csRise  = csN & ~csQ;

  // input assembly: one transfer per rising edge
  generate
    if (XFERS == 1) begin : g_wide
      assign byteVal   = dataIn;
      assign byteValid = sckRise & ~csN;
      assign partial   = 1'b0;
    end else begin : g_serial
      logic [7:0]       inShift;
      logic [SUB_W-1:0] xferCnt;

      assign byteVal   = {inShift[7-BUS_W:0], dataIn};
      assign byteValid = sckRise & ~csN & (xferCnt == SUB_W'(XFERS - 1));
      assign partial   = (xferCnt != '0);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          inShift <= '0;
          xferCnt <= '0;
        end else if (csN) begin
          xferCnt <= '0;
        end else if (sckRise) begin
          inShift <= byteVal;
          xferCnt <= xferCnt + 1'b1;
        end
      end
    end
  endgenerate

  // data buffer and protection storage
  logic [NUM_SECTORS-1:0][7:0] bufMem;
  logic [NUM_SECTORS-1:0][7:0] protReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufMem <= '0;
    end else if (strobe.bufWe) begin
      bufMem[strobe.bufIdx] <= byteVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protReg <= '0;
    end else if (strobe.commit) begin
      protReg <= bufMem;
    end
  end

  // read stream position, in transfers, saturating on the filler
  logic [POS_W-1:0] outPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPos <= '0;
    end else if (strobe.outLoad) begin
      outPos <= '0;
    end else if (strobe.outStep && (outPos != POS_W'(POS_SAT))) begin
      outPos <= outPos + 1'b1;
    end
  end

  logic [POS_W-1:0]      byteSel;
  logic [POS_W-1:0]      subSel;
  logic [SECT_IDX_W-1:0] sectSel;
  logic [7:0]            curByte;
  int                    laneSel;

  always_comb begin
    byteSel = outPos >> SUB_W;
    subSel  = outPos - (byteSel << SUB_W);
    sectSel = byteSel[SECT_IDX_W-1:0];
    curByte = (byteSel < POS_W'(NUM_SECTORS)) ? protReg[sectSel] : FILL_BYTE;
    laneSel = XFERS - 1 - int'(subSel);
    dataOut = strobe.outEn ? curByte[laneSel*BUS_W +: BUS_W] : '0;
  end

  // R8
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.commit) |-> $stable(protReg));

  // R4
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    outPos <= POS_W'(POS_SAT));

endmodule

// File: rtl/prot_flash_ctrl.sv
module prot_flash_ctrl
  import prot_flash_pkg::*;
#(
  parameter int BUS_W = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       csRise,
  input  logic       sckFall,
  input  logic       byteValid,
  input  logic [7:0] byteVal,
  input  logic       partial,
  output dpStrobe_t  strobe
);

  localparam int DUMMY   = (BUS_W == 8) ? 7 : 3;
  localparam int DCNT_W  = 3;
  localparam int DATA_W  = SECT_IDX_W + 1;

  ctrlState_t        state;
  logic [1:0]        hdrIdx;
  logic [DCNT_W-1:0] dummyCnt;
  logic [DATA_W-1:0] dataCnt;
  logic              pending;
  logic              active;

  always_comb begin
    strobe.bufWe   = (state == ST_PGMDATA) && byteValid &&
                     (dataCnt < DATA_W'(NUM_SECTORS));
    strobe.bufIdx  = dataCnt[SECT_IDX_W-1:0];
    strobe.commit  = csRise && (state == ST_PGMDATA) && !partial;
    strobe.outLoad = (state == ST_RDDATA) && pending && sckFall && !csN;
    strobe.outStep = active && sckFall && !csN;
    strobe.outEn   = active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OPCODE;
      hdrIdx   <= '0;
      dummyCnt <= '0;
      dataCnt  <= '0;
      pending  <= 1'b0;
      active   <= 1'b0;
    end else if (csN) begin
      state    <= ST_OPCODE;
      hdrIdx   <= '0;
      dummyCnt <= '0;
      dataCnt  <= '0;
      pending  <= 1'b0;
      active   <= 1'b0;
    end else begin
      if (byteValid) begin
        case (state)
          ST_OPCODE: begin
            if (byteVal == OP_READ) begin
              state    <= ST_RDDUMMY;
              dummyCnt <= '0;
            end else if (byteVal == progByte(2'd0)) begin
              state  <= ST_PGMHDR;
              hdrIdx <= 2'd1;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_PGMHDR: begin
            if (byteVal != progByte(hdrIdx)) begin
              state <= ST_IGNORE;
            end else if (hdrIdx == 2'd3) begin
              state   <= ST_PGMDATA;
              dataCnt <= '0;
            end else begin
              hdrIdx <= hdrIdx + 1'b1;
            end
          end
          ST_PGMDATA: begin
            if (dataCnt < DATA_W'(NUM_SECTORS)) dataCnt <= dataCnt + 1'b1;
          end
          ST_RDDUMMY: begin
            if (dummyCnt == DCNT_W'(DUMMY - 1)) begin
              state   <= ST_RDDATA;
              pending <= 1'b1;
            end else begin
              dummyCnt <= dummyCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (strobe.outLoad) begin
        pending <= 1'b0;
        active  <= 1'b1;
      end
    end
  end

  // R7
  ignore_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE && !csN) |=> (state == ST_IGNORE));

  // R2
  dummy_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RDDATA && $past(state) == ST_RDDUMMY) |->
      ($past(dummyCnt) == DCNT_W'(DUMMY - 1)));

  // R5
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !strobe.outEn);

  // R3
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.outEn) |-> $past(sckFall));

  // R10
  data_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataCnt <= DATA_W'(NUM_SECTORS));

endmodule

// File: rtl/prot_flash_responder.sv
module prot_flash_responder
  import prot_flash_pkg::*;
#(
  parameter int BUS_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sck,
  input  logic [BUS_W-1:0] dataIn,
  output logic [BUS_W-1:0] dataOut,
  output logic             dataOutEn
);

  dpStrobe_t  strobe;
  logic       sckFall;
  logic       csRise;
  logic       byteValid;
  logic [7:0] byteVal;
  logic       partial;

  prot_flash_ctrl #(.BUS_W(BUS_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .csRise    (csRise),
    .sckFall   (sckFall),
    .byteValid (byteValid),
    .byteVal   (byteVal),
    .partial   (partial),
    .strobe    (strobe)
  );

  prot_flash_dp #(.BUS_W(BUS_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sck       (sck),
    .dataIn    (dataIn),
    .strobe    (strobe),
    .sckFall   (sckFall),
    .csRise    (csRise),
    .byteValid (byteValid),
    .byteVal   (byteVal),
    .partial   (partial),
    .dataOut   (dataOut)
  );

  assign dataOutEn = strobe.outEn;

endmodule

// File: tb/prot_flash_responder_tb_top.sv
module prot_flash_tb_lane #(
  parameter int BUS_W = 1
) (
  input  logic clk,
  input  logic rstN,
  output int   nChecks,
  output int   nFails,
  output logic done
);

  localparam int XF    = 8 / BUS_W;
  localparam int DUMMY = (BUS_W == 8) ? 7 : 3;
  localparam int NS    = 32;

  logic             csN = 1'b1;
  logic             sck = 1'b0;
  logic [BUS_W-1:0] din = '0;
  logic [BUS_W-1:0] dout;
  logic             oe;

  prot_flash_responder #(.BUS_W(BUS_W)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sck       (sck),
    .dataIn    (din),
    .dataOut   (dout),
    .dataOutEn (oe)
  );

  logic [7:0]       expReg [NS];
  logic [7:0]       expBuf [NS];
  logic [7:0]       pd     [40];
  logic [BUS_W-1:0] sv     [512];
  logic             so     [512];
  int               sn;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s (W=%0d) %s: actual %0h expected %0h", req, BUS_W, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [BUS_W-1:0] v);
    @(negedge clk);
    din = v;
    sck = 1'b1;
    repeat (2) @(negedge clk);
    sck = 1'b0;
    repeat (3) @(negedge clk);
    if (sn < 512) begin
      sv[sn] = dout;
      so[sn] = oe;
      sn++;
    end
  endtask

  task automatic sendXfers(input logic [7:0] b, input int n);
    for (int t = 0; t < n; t++) xfer(b[(XF-1-t)*BUS_W +: BUS_W]);
  endtask

  task automatic sendByte(input logic [7:0] b);
    sendXfers(b, XF);
  endtask

  task automatic selectDev();
    @(negedge clk);
    csN = 1'b0;
    sn  = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic releaseDev();
    @(negedge clk);
    csN = 1'b1;
    repeat (3) @(negedge clk);
    // R5: enable drops once select is high
    check(oe == 1'b0, "R5", "enable after release", int'(oe), 0);
  endtask

  task automatic fillPat(input int seed);
    for (int i = 0; i < 40; i++) pd[i] = 8'((i * 29 + seed * 71 + 5) ^ (seed << 3));
  endtask

  task automatic doProgram(input logic [31:0] hdr, input int n, input int extraXf);
    bit valid;
    valid = (hdr == 32'h3D2A7FFC);
    selectDev();
    for (int h = 0; h < 4; h++) sendByte(hdr[31-8*h -: 8]);
    for (int i = 0; i < n; i++) begin
      sendByte(pd[i]);
      if (valid && i < NS) expBuf[i] = pd[i];
    end
    if (extraXf > 0) sendXfers(8'hA5, extraXf);
    releaseDev();
    if (valid && extraXf == 0)
      for (int i = 0; i < NS; i++) expReg[i] = expBuf[i];
  endtask

  task automatic readAll(input string req);
    int k0;
    int badOe;
    logic [7:0] b;
    bit oeAll;
    selectDev();
    sendByte(8'h32);
    for (int d = 0; d < DUMMY; d++) sendByte(8'h00);
    for (int j = 0; j < 34; j++) sendByte(8'h00);
    releaseDev();
    k0 = (1 + DUMMY) * XF - 1;
    badOe = 0;
    for (int k = 0; k < k0; k++) if (so[k]) badOe++;
    // R2: silent through opcode and dummy bytes
    check(badOe == 0, "R2", "enable during opcode/dummy", badOe, 0);
    for (int j = 0; j < 34; j++) begin
      b = '0;
      oeAll = 1'b1;
      for (int t = 0; t < XF; t++) begin
        b = 8'((b << BUS_W) | sv[k0 + j*XF + t]);
        oeAll = oeAll & so[k0 + j*XF + t];
      end
      if (j < NS) begin
        // R3: sector-ordered data, R1/R6/R7/R8/R9/R10 through expReg
        check(oeAll && b == expReg[j], req, $sformatf("sector %0d", j), int'(b), int'(expReg[j]));
      end else begin
        // R4: filler after the last sector
        check(oeAll && b == 8'hFF, "R4", $sformatf("filler %0d", j - NS), int'(b), 255);
      end
    end
  endtask

  initial begin
    int highs;
    nChecks = 0;
    nFails  = 0;
    done    = 1'b0;
    for (int i = 0; i < NS; i++) begin
      expReg[i] = 8'h00;
      expBuf[i] = 8'h00;
    end
    @(posedge rstN);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(oe == 1'b0, "R1", "enable after reset", int'(oe), 0);
    readAll("R1");

    // R3 R8: full programs with several patterns
    for (int s = 1; s <= 3; s++) begin
      fillPat(s);
      doProgram(32'h3D2A7FFC, 32, 0);
      readAll("R3");
    end

    // R10: extra data bytes ignored
    fillPat(4);
    doProgram(32'h3D2A7FFC, 37, 0);
    readAll("R10");

    // R8: short program keeps older buffer bytes in upper sectors
    fillPat(5);
    doProgram(32'h3D2A7FFC, 5, 0);
    readAll("R8");

    // R6: each header byte after the first corrupted in turn
    for (int c = 1; c <= 3; c++) begin
      fillPat(6 + c);
      doProgram(32'h3D2A7FFC ^ (32'h01 << (8 * (3 - c))), 32, 0);
      readAll("R6");
    end

    // R7: unknown opcode, then a read in the same selection
    selectDev();
    sendByte(8'hA5);
    sendByte(8'h32);
    for (int d = 0; d < DUMMY + 4; d++) sendByte(8'h00);
    highs = 0;
    for (int k = 0; k < sn; k++) if (so[k]) highs++;
    check(highs == 0, "R7", "enable after unknown opcode", highs, 0);
    releaseDev();

    // R7: unknown opcode, then a full program in the same selection
    fillPat(12);
    selectDev();
    sendByte(8'h00);
    sendByte(8'h3D); sendByte(8'h2A); sendByte(8'h7F); sendByte(8'hFC);
    for (int i = 0; i < 8; i++) sendByte(pd[i]);
    releaseDev();
    readAll("R7");

    // R9: partial final byte discards the commit; buffer keeps whole bytes
    if (XF > 1) begin
      fillPat(13);
      doProgram(32'h3D2A7FFC, 6, 3);
      readAll("R9");
      doProgram(32'h3D2A7FFC, 0, 0);
      readAll("R8");
    end

    // R5: select released mid-read, next read restarts at sector 0
    selectDev();
    sendByte(8'h32);
    for (int d = 0; d < DUMMY + 2; d++) sendByte(8'h00);
    releaseDev();
    readAll("R5");

    done = 1'b1;
  end

endmodule

module prot_flash_responder_tb_top;

  localparam int LIMIT = 190000;

  logic clk  = 1'b0;
  logic rstN = 1'b0;

  always #10 clk = ~clk;

  int   c1, f1, c8, f8;
  logic d1, d8;

  prot_flash_tb_lane #(.BUS_W(1)) serialLane (
    .clk (clk), .rstN (rstN), .nChecks (c1), .nFails (f1), .done (d1)
  );

  prot_flash_tb_lane #(.BUS_W(8)) wideLane (
    .clk (clk), .rstN (rstN), .nChecks (c8), .nFails (f8), .done (d8)
  );

  initial begin
    int cyc;
    int wd;
    cyc = 0;
    wd  = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    while (!(d1 && d8) && cyc < LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    if (!(d1 && d8)) begin
      wd = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures",
             c1 + c8 + wd, f1 + f8 + wd);
    $finish;
  end

endmodule